// File: doc/BRIEF.md
# Pointer-Indexed Register Access Controller

This block sits behind a two-wire serial slave byte engine. It turns transaction events into register reads and writes through a single address pointer. The byte engine reports five events: a start or repeated start, an address match with its direction, each received data byte, each request for a byte to transmit, and a stop. The controller keeps the pointer across transactions. In every write transaction, the first data byte loads the pointer and the second data byte is written to the register that the pointer selects. A read transaction returns the register at the current pointer, with no pointer write needed first.

The register map is small and deliberately asymmetric. The configuration register is read at one pointer value and written at another. The consecutive-alert register uses the same pointer value for reading and writing. A write-only trigger location produces a one-cycle conversion request whatever data is written to it. The control bits that matter are driven onto output ports for the neighbouring alert and conversion logic.

Top module: `ptr_reg_ctrl`

## Requirements
- R1: After reset, the pointer is 0x00, every control output and `conv_req` are 0, and the configuration and consecutive-alert registers hold 0x00.
- R2: In a write transaction, the first data byte is stored into the pointer and changes no register.
- R3: A read transaction returns, one cycle after `rd_req`, the register selected by the current pointer. The pointer keeps its value across transactions and is not changed by reads.
- R4: The configuration register reads at pointer 0x03 and is written at pointer 0x09. A data byte written at pointer 0x03 is ignored.
- R5: Configuration bit positions map to outputs as follows: bit 7 drives `mask_all`, bit 6 drives `standby`, bit 1 drives `mask_rem1` and bit 0 drives `mask_rem2`. Each output follows the new value one cycle after the data byte.
- R6: The consecutive-alert register is read and written at pointer 0x22, and its bit 5 drives `mask_local`.
- R7: A data byte written at pointer 0x0F raises `conv_req` for exactly one cycle, starting one cycle after the byte. The data is discarded and no register changes.
- R8: The third and later data bytes of a write transaction are ignored.
- R9: Reads at write-only pointers (0x09, 0x0F) or at unmapped pointers return 0x00.
- R10: A start, repeated start or stop ends the current byte count, so the first data byte after the next write address match loads the pointer again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Start or repeated start seen (one-cycle pulse) |
| ev_stop | input | 1 | Stop seen (one-cycle pulse) |
| ev_addr_match | input | 1 | Own slave address matched (one-cycle pulse) |
| addr_rd | input | 1 | Direction bit of the matched address, 1 = read |
| ev_byte_rx | input | 1 | Data byte received from the master (one-cycle pulse) |
| rx_byte | input | 8 | Received data byte, valid with `ev_byte_rx` |
| rd_req | input | 1 | Byte engine requests a byte to transmit (one-cycle pulse) |
| rd_byte | output | 8 | Byte to transmit, valid the cycle after `rd_req` |
| conv_req | output | 1 | One-cycle conversion request |
| mask_all | output | 1 | Global alert mask |
| standby | output | 1 | Standby control |
| mask_rem1 | output | 1 | Remote channel 1 alert mask |
| mask_rem2 | output | 1 | Remote channel 2 alert mask |
| mask_local | output | 1 | Local channel alert mask |

## Verification
The bench builds the block with its default parameters: an 8-bit data path and the 0x03/0x09 read/write pair, 0x22 and 0x0F as the map locations. With these values the pointer can reach every mapped location, both halves of the split configuration address, and unmapped values such as 0x00 and 0x55. Repeated-start sequences and over-long writes are driven at these same addresses, so that the byte-count reset and the data drop after the second byte both fall on registers that can be read back.

// File: rtl/ptrreg_pkg.sv
package ptrreg_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PTR  = 2'd1,
        PH_DATA = 2'd2,
        PH_DROP = 2'd3
    } wph_e;

    localparam int unsigned CFG_ALL_BIT   = 7;
    localparam int unsigned CFG_STBY_BIT  = 6;
    localparam int unsigned CFG_REM1_BIT  = 1;
    localparam int unsigned CFG_REM2_BIT  = 0;
    localparam int unsigned CAL_LOCAL_BIT = 5;
endpackage

// File: rtl/ptr_ctrl.sv
module ptr_ctrl
    import ptrreg_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_start,
    input  logic          ev_stop,
    input  logic          ev_addr_match,
    input  logic          addr_rd,
    input  logic          ev_byte_rx,
    input  logic [DW-1:0] rx_byte,
    output logic [DW-1:0] ptr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data
);
    typedef struct packed {
        wph_e          phase;
        logic [DW-1:0] ptr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        if (ev_start || ev_stop) begin
            st_d.phase = PH_IDLE;
        end else if (ev_addr_match) begin
            st_d.phase = addr_rd ? PH_IDLE : PH_PTR;
        end else if (ev_byte_rx) begin
            case (st_q.phase)
                PH_PTR: begin
                    st_d.ptr   = rx_byte;
                    st_d.phase = PH_DATA;
                end
                PH_DATA: begin
                    wr_en      = 1'b1;
                    st_d.phase = PH_DROP;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, ptr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr     = st_q.ptr;
    assign wr_data = rx_byte;

    // R2: the first byte after a write address match lands in the pointer
    a_r2_ptr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_byte_rx && !ev_start && !ev_stop && !ev_addr_match && st_q.phase == PH_PTR)
        |=> (ptr == $past(rx_byte)));

    // R3: the pointer only moves on a received byte
    a_r3_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_byte_rx |=> $stable(ptr));

    // R8: once the data byte is taken, no further write strobes in this transaction
    a_r8_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

// File: rtl/reg_file.sv
module reg_file
    import ptrreg_pkg::*;
#(
    parameter int unsigned  DW          = 8,
    parameter logic [DW-1:0] CFG_RD_ADDR = 8'h03,
    parameter logic [DW-1:0] CFG_WR_ADDR = 8'h09,
    parameter logic [DW-1:0] CAL_ADDR    = 8'h22,
    parameter logic [DW-1:0] SHOT_ADDR   = 8'h0F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] ptr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    output logic [DW-1:0] rd_byte,
    output logic          conv_req,
    output logic          mask_all,
    output logic          standby,
    output logic          mask_rem1,
    output logic          mask_rem2,
    output logic          mask_local
);
    typedef struct packed {
        logic [DW-1:0] cfg;
        logic [DW-1:0] cal;
        logic [DW-1:0] rd;
        logic          conv;
    } rf_t;

    rf_t rf_d, rf_q;

    always_comb begin
        rf_d      = rf_q;
        rf_d.conv = 1'b0;
        if (wr_en) begin
            if (ptr == CFG_WR_ADDR) begin
                rf_d.cfg = wr_data;
            end else if (ptr == CAL_ADDR) begin
                rf_d.cal = wr_data;
            end else if (ptr == SHOT_ADDR) begin
                rf_d.conv = 1'b1;
            end
        end
        if (rd_req) begin
            if (ptr == CFG_RD_ADDR) begin
                rf_d.rd = rf_q.cfg;
            end else if (ptr == CAL_ADDR) begin
                rf_d.rd = rf_q.cal;
            end else begin
                rf_d.rd = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rf_q <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    assign rd_byte    = rf_q.rd;
    assign conv_req   = rf_q.conv;
    assign mask_all   = rf_q.cfg[CFG_ALL_BIT];
    assign standby    = rf_q.cfg[CFG_STBY_BIT];
    assign mask_rem1  = rf_q.cfg[CFG_REM1_BIT];
    assign mask_rem2  = rf_q.cfg[CFG_REM2_BIT];
    assign mask_local = rf_q.cal[CAL_LOCAL_BIT];

    // R4: data written at the read-side configuration address is dropped
    a_r4_ro_alias: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == CFG_RD_ADDR) |=> $stable(rf_q.cfg));

    // R9: a read away from the readable locations yields zero
    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && ptr != CFG_RD_ADDR && ptr != CAL_ADDR) |=> (rd_byte == '0));

    // R7: the conversion request is one cycle wide
    a_r7_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |=> !conv_req);

    // R7: the trigger write leaves both storage registers untouched
    a_r7_no_side_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ptr == SHOT_ADDR) |=> ($stable(rf_q.cfg) && $stable(rf_q.cal)));
endmodule

// File: rtl/ptr_reg_ctrl.sv
module ptr_reg_ctrl
    import ptrreg_pkg::*;
#(
    parameter int unsigned  DW          = 8,
    parameter logic [DW-1:0] CFG_RD_ADDR = 8'h03,
    parameter logic [DW-1:0] CFG_WR_ADDR = 8'h09,
    parameter logic [DW-1:0] CAL_ADDR    = 8'h22,
    parameter logic [DW-1:0] SHOT_ADDR   = 8'h0F
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_start,
    input  logic          ev_stop,
    input  logic          ev_addr_match,
    input  logic          addr_rd,
    input  logic          ev_byte_rx,
    input  logic [DW-1:0] rx_byte,
    input  logic          rd_req,
    output logic [DW-1:0] rd_byte,
    output logic          conv_req,
    output logic          mask_all,
    output logic          standby,
    output logic          mask_rem1,
    output logic          mask_rem2,
    output logic          mask_local
);
    logic [DW-1:0] ptr;
    logic          wr_en;
    logic [DW-1:0] wr_data;

    ptr_ctrl #(.DW(DW)) u_ptr (
        .clk           (clk),
        .rst_n         (rst_n),
        .ev_start      (ev_start),
        .ev_stop       (ev_stop),
        .ev_addr_match (ev_addr_match),
        .addr_rd       (addr_rd),
        .ev_byte_rx    (ev_byte_rx),
        .rx_byte       (rx_byte),
        .ptr           (ptr),
        .wr_en         (wr_en),
        .wr_data       (wr_data)
    );

    reg_file #(
        .DW          (DW),
        .CFG_RD_ADDR (CFG_RD_ADDR),
        .CFG_WR_ADDR (CFG_WR_ADDR),
        .CAL_ADDR    (CAL_ADDR),
        .SHOT_ADDR   (SHOT_ADDR)
    ) u_rf (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr        (ptr),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_req     (rd_req),
        .rd_byte    (rd_byte),
        .conv_req   (conv_req),
        .mask_all   (mask_all),
        .standby    (standby),
        .mask_rem1  (mask_rem1),
        .mask_rem2  (mask_rem2),
        .mask_local (mask_local)
    );

    // R1: no conversion request may appear unless a write strobe preceded it
    a_r1_quiet_conv: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> $past(wr_en));
endmodule

// File: tb/sim_ptr_reg_ctrl.sv
module sim_ptr_reg_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_start = 1'b0, ev_stop = 1'b0, ev_addr_match = 1'b0, addr_rd = 1'b0;
    logic       ev_byte_rx = 1'b0, rd_req = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] rd_byte;
    logic       conv_req, mask_all, standby, mask_rem1, mask_rem2, mask_local;

    int checks = 0;
    int fails  = 0;
    int conv_cnt = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ptr_reg_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_addr_match(ev_addr_match), .addr_rd(addr_rd), .ev_byte_rx(ev_byte_rx),
        .rx_byte(rx_byte), .rd_req(rd_req), .rd_byte(rd_byte), .conv_req(conv_req),
        .mask_all(mask_all), .standby(standby), .mask_rem1(mask_rem1),
        .mask_rem2(mask_rem2), .mask_local(mask_local)
    );

    always @(posedge clk) if (rst_n && conv_req) conv_cnt <= conv_cnt + 1;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic ev_pulse(input int which, input logic [7:0] b);
        @(negedge clk);
        case (which)
            0: ev_start = 1'b1;
            1: ev_stop = 1'b1;
            2: begin ev_addr_match = 1'b1; addr_rd = b[0]; end
            3: begin ev_byte_rx = 1'b1; rx_byte = b; end
            default: rd_req = 1'b1;
        endcase
        @(negedge clk);
        ev_start = 1'b0; ev_stop = 1'b0; ev_addr_match = 1'b0;
        ev_byte_rx = 1'b0; rd_req = 1'b0;
    endtask

    task automatic wr_txn(input int n, input logic [7:0] b0, input logic [7:0] b1,
                          input logic [7:0] b2);
        ev_pulse(0, 8'h00);
        ev_pulse(2, 8'h00);
        if (n > 0) ev_pulse(3, b0);
        if (n > 1) ev_pulse(3, b1);
        if (n > 2) ev_pulse(3, b2);
        ev_pulse(1, 8'h00);
    endtask

    task automatic rd_txn(output logic [7:0] v);
        ev_pulse(0, 8'h00);
        ev_pulse(2, 8'h01);
        ev_pulse(4, 8'h00);
        v = rd_byte;
        ev_pulse(1, 8'h00);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R1 outputs", {3'b0, mask_all, standby, mask_rem1, mask_rem2, mask_local}, 8'h00);
        chk("R1 conv_req", {7'b0, conv_req}, 8'h00);
        rd_txn(v);
        chk("R1/R9 read at reset pointer 0x00", v, 8'h00);
    endtask

    task automatic t_config;
        logic [7:0] v;
        wr_txn(2, 8'h09, 8'hC3, 8'h00);
        chk("R5 bits after C3", {4'b0, mask_all, standby, mask_rem1, mask_rem2}, 8'h0F);
        rd_txn(v);
        chk("R9 read at write-only 0x09", v, 8'h00);
        wr_txn(1, 8'h03, 8'h00, 8'h00);
        chk("R2 pointer-only write leaves config", {4'b0, mask_all, standby, mask_rem1, mask_rem2}, 8'h0F);
        rd_txn(v);
        chk("R4 read config at 0x03", v, 8'hC3);
        rd_txn(v);
        chk("R3 pointer retained across reads", v, 8'hC3);
        wr_txn(2, 8'h03, 8'h00, 8'h00);
        rd_txn(v);
        chk("R4 write at read address ignored", v, 8'hC3);
        wr_txn(2, 8'h09, 8'h82, 8'h00);
        chk("R5 bits after 82", {4'b0, mask_all, standby, mask_rem1, mask_rem2}, 8'h0A);
    endtask

    task automatic t_cal;
        logic [7:0] v;
        wr_txn(2, 8'h22, 8'h20, 8'h00);
        chk("R6 mask_local set", {7'b0, mask_local}, 8'h01);
        rd_txn(v);
        chk("R6 read 0x22", v, 8'h20);
        wr_txn(2, 8'h22, 8'h00, 8'h00);
        chk("R6 mask_local clear", {7'b0, mask_local}, 8'h00);
        wr_txn(3, 8'h22, 8'h20, 8'hFF);
        rd_txn(v);
        chk("R8 third byte dropped", v, 8'h20);
    endtask

    task automatic t_oneshot;
        logic [7:0] v;
        int c0;
        c0 = conv_cnt;
        wr_txn(1, 8'h0F, 8'h00, 8'h00);
        chk("R7 pointer-only at 0x0F no pulse", 8'(conv_cnt - c0), 8'h00);
        wr_txn(2, 8'h0F, 8'h5A, 8'h00);
        chk("R7 one pulse cycle", 8'(conv_cnt - c0), 8'h01);
        rd_txn(v);
        chk("R9 read at 0x0F", v, 8'h00);
        wr_txn(1, 8'h03, 8'h00, 8'h00);
        rd_txn(v);
        chk("R7 config untouched by trigger", v, 8'h82);
        wr_txn(1, 8'h55, 8'h00, 8'h00);
        rd_txn(v);
        chk("R9 unmapped 0x55", v, 8'h00);
    endtask

    task automatic t_restart;
        logic [7:0] v;
        ev_pulse(0, 8'h00);
        ev_pulse(2, 8'h00);
        ev_pulse(3, 8'h22);
        ev_pulse(0, 8'h00);
        ev_pulse(2, 8'h00);
        ev_pulse(3, 8'h09);
        ev_pulse(3, 8'h01);
        ev_pulse(1, 8'h00);
        chk("R10 repeated start reloads pointer", {4'b0, mask_all, standby, mask_rem1, mask_rem2}, 8'h01);
        wr_txn(1, 8'h22, 8'h00, 8'h00);
        rd_txn(v);
        chk("R10 0x22 not written", v, 8'h20);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_config;
        t_cal;
        t_oneshot;
        t_restart;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule